// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

A synthesizable single-port synchronous SRAM with a registered read pipeline. A command is taken on every enabled rising clock edge: a read, a write or a deselect. Write data arrives two enabled edges after its write command. Read data leaves the output register two enabled edges after its read command. Because both directions share the same two-edge spacing, the data bus can swap direction on any cycle with no idle cycle between a write and a read.

A write travels through two address and lane-select stages before it reaches the array. A read that arrives just behind a write to the same word gets that write's lanes from a forwarding register and the remaining lanes from the array. A two-bit burst counter steps the low address bits in linear or interleaved order. The pads are modelled as a data-out bus with a valid flag. The flag is gated asynchronously by an output enable and is low in every cycle that carries write data. A clock enable freezes the whole block. A sleep input forces deselect.

Top module: `zero_turn_sram`

## Requirements
- R1: A read command taken at enabled edge t drives its word on `rdata` with `rvalid` high after enabled edge t+2, provided `out_en` is high and `sleep` is low at edge t+2.
- R2: The data for a write command taken at enabled edge t is sampled from `wdata` at enabled edge t+2. Only lanes whose `lane_we` bit was 1 in the command cycle are updated. Lane k is `wdata[k*LANE_W +: LANE_W]`.
- R3: A read always returns the newest written value of every lane, including writes still in the pipeline. Any interleaving of reads and writes needs no idle cycles.
- R4: An edge with `clk_en` low changes no state and no output.
- R5: A load cycle (`adv`=0) starts an access only when `sel_n1`=0, `sel_p2`=1 and `sel_n3`=0. In any other case the cycle is a deselect, gives no output two edges later, and ends any burst.
- R6: `out_en` low forces `rvalid` to 0 and `rdata` to all zeros in the same cycle, without waiting for a clock edge.
- R7: `rvalid` is 0 after the enabled edge that samples write data.
- R8: With `adv`=1 during a burst, the command repeats the burst's operation. Its address keeps the upper bits and sets the low two bits to (start + k) mod 4 when the burst is linear, where k counts the advance cycles. `lane_we` is taken anew on each cycle.
- R9: When `burst_ilv` is 1 at the load cycle, the low two bits become start XOR (k mod 4). `burst_ilv` is sampled only on the load cycle.
- R10: `adv`=1 with no burst active, for example after reset or a deselect, is a deselect.
- R11: `sleep` high at an enabled edge turns the command into a deselect, ends any burst, and clears `rvalid` after that edge. Array contents are kept.
- R12: Reset (synchronous, active high) clears `rvalid`, empties the pipeline and ends any burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| clk_en | input | 1 | Edge qualifier; low freezes the block |
| sleep | input | 1 | Low-power request; forces deselect |
| sel_n1 | input | 1 | Chip select, active low |
| sel_p2 | input | 1 | Chip select, active high |
| sel_n3 | input | 1 | Chip select, active low |
| adv | input | 1 | 1 = advance burst, 0 = load new address |
| wr_en | input | 1 | 1 = write, 0 = read (load cycles only) |
| lane_we | input | LANES | Per-lane write select |
| addr | input | ADDR_W | Word address |
| wdata | input | LANES*LANE_W | Write data, two edges after the command |
| burst_ilv | input | 1 | 1 = interleaved burst order, 0 = linear |
| out_en | input | 1 | Asynchronous output enable |
| rdata | output | LANES*LANE_W | Read data, zero when not valid |
| rvalid | output | 1 | Output drive flag |

## Verification
Two events can fall on the same edge: a pipelined write entering the array, and the synchronous array read for a later command to the same word. Without forwarding, that read would return the old word. The bench provokes this with writes to a word followed at once by reads of it, using partial lane masks. It does so in directed sequences, in bursts and in long random traffic with clock-enable gaps. Every result is judged against a bench memory that applies each write at its data edge and reads the word at the read's output edge.

// File: rtl/zt_pkg.sv
package zt_pkg;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;

  // low two address bits for burst beat 'step' from 'start'
  function automatic logic [1:0] burst_low(input logic [1:0] start,
                                           input logic [1:0] step,
                                           input logic       ilv);
    return ilv ? (start ^ step) : (start + step);
  endfunction

endpackage

// File: rtl/zt_cmd_decode.sv
module zt_cmd_decode
  import zt_pkg::*;
#(
  parameter int AW = 6,
  parameter int LN = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clk_en,
  input  logic          sleep,
  input  logic          sel_n1,
  input  logic          sel_p2,
  input  logic          sel_n3,
  input  logic          adv,
  input  logic          wr_en,
  input  logic          burst_ilv,
  input  logic [LN-1:0] lane_we,
  input  logic [AW-1:0] addr,
  output op_e           cmd_op,
  output logic [AW-1:0] cmd_addr,
  output logic [LN-1:0] cmd_lanes
);

  logic          bst_act;
  logic          bst_ilv;
  op_e           bst_op;
  logic [AW-1:0] bst_base;
  logic [1:0]    bst_cnt;
  logic [1:0]    cnt_nx;
  logic          chips_on;

  assign chips_on = !sel_n1 && sel_p2 && !sel_n3;
  assign cnt_nx   = bst_cnt + 2'd1;

  always_comb begin
    cmd_op    = OP_IDLE;
    cmd_addr  = addr;
    cmd_lanes = lane_we;
    if (!sleep) begin
      if (!adv) begin
        if (chips_on) cmd_op = wr_en ? OP_WR : OP_RD;
      end else if (bst_act) begin
        cmd_op   = bst_op;
        cmd_addr = {bst_base[AW-1:2], burst_low(bst_base[1:0], cnt_nx, bst_ilv)};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bst_act  <= 1'b0;
      bst_ilv  <= 1'b0;
      bst_op   <= OP_IDLE;
      bst_base <= '0;
      bst_cnt  <= '0;
    end else if (clk_en) begin
      if (sleep) begin
        bst_act <= 1'b0;
      end else if (!adv) begin
        bst_act  <= chips_on;
        bst_op   <= wr_en ? OP_WR : OP_RD;
        bst_base <= addr;
        bst_cnt  <= '0;
        bst_ilv  <= burst_ilv;
      end else if (bst_act) begin
        bst_cnt <= cnt_nx;
      end
    end
  end

endmodule

// File: rtl/zt_write_registry.sv
module zt_write_registry
  import zt_pkg::*;
#(
  parameter int AW = 6,
  parameter int LN = 4,
  parameter int LW = 9,
  localparam int DW = LN * LW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clk_en,
  input  op_e           cmd_op,
  input  logic [AW-1:0] cmd_addr,
  input  logic [LN-1:0] cmd_lanes,
  input  logic [DW-1:0] wdata,
  output op_e           a_op,
  output op_e           b_op,
  output logic [AW-1:0] a_addr,
  output logic [AW-1:0] b_addr,
  output logic          wr_go,
  output logic [LN-1:0] wr_lanes,
  output logic [LN-1:0] fwd_lanes,
  output logic [DW-1:0] fwd_data
);

  logic [LN-1:0] a_lanes;
  logic          fw_vld;
  logic [AW-1:0] fw_addr;
  logic [LN-1:0] fw_lanes;
  logic [DW-1:0] fw_data;

  // two delay stages for address, operation and lane selects
  always_ff @(posedge clk) begin
    if (rst) begin
      a_op     <= OP_IDLE;
      b_op     <= OP_IDLE;
      a_addr   <= '0;
      b_addr   <= '0;
      a_lanes  <= '0;
      wr_lanes <= '0;
    end else if (clk_en) begin
      a_op     <= cmd_op;
      a_addr   <= cmd_addr;
      a_lanes  <= cmd_lanes;
      b_op     <= a_op;
      b_addr   <= a_addr;
      wr_lanes <= a_lanes;
    end
  end

  assign wr_go = (b_op == OP_WR);

  // newest committed write, kept one cycle for the read that trails it
  always_ff @(posedge clk) begin
    if (rst) begin
      fw_vld   <= 1'b0;
      fw_addr  <= '0;
      fw_lanes <= '0;
      fw_data  <= '0;
    end else if (clk_en) begin
      fw_vld   <= wr_go;
      fw_addr  <= b_addr;
      fw_lanes <= wr_lanes;
      fw_data  <= wdata;
    end
  end

  assign fwd_lanes = (fw_vld && (b_op == OP_RD) && (fw_addr == b_addr)) ? fw_lanes : '0;
  assign fwd_data  = fw_data;

endmodule

// File: rtl/zt_array.sv
module zt_array #(
  parameter int AW = 6,
  parameter int LN = 4,
  parameter int LW = 9,
  localparam int DW    = LN * LW,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          clk_en,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [LN-1:0] wlanes,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rq
);

  logic [DW-1:0] mem [DEPTH];

  // read-first block memory with per-lane write enables
  always_ff @(posedge clk) begin
    if (clk_en) begin
      for (int i = 0; i < LN; i++) begin
        if (we && wlanes[i]) mem[waddr][i*LW +: LW] <= wdata[i*LW +: LW];
      end
      rq <= mem[raddr];
    end
  end

endmodule

// File: rtl/zt_out_stage.sv
module zt_out_stage #(
  parameter int LN = 4,
  parameter int LW = 9,
  localparam int DW = LN * LW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clk_en,
  input  logic          sleep,
  input  logic          rd_done,
  input  logic [DW-1:0] ram_q,
  input  logic [LN-1:0] fwd_lanes,
  input  logic [DW-1:0] fwd_data,
  input  logic          out_en,
  output logic          drive_q,
  output logic [DW-1:0] q_reg,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);

  logic [DW-1:0] merged;

  for (genvar g = 0; g < LN; g++) begin : g_lane
    assign merged[g*LW +: LW] = fwd_lanes[g] ? fwd_data[g*LW +: LW] : ram_q[g*LW +: LW];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      drive_q <= 1'b0;
      q_reg   <= '0;
    end else if (clk_en) begin
      drive_q <= rd_done && !sleep;
      if (rd_done) q_reg <= merged;
    end
  end

  assign rvalid = drive_q && out_en;
  assign rdata  = rvalid ? q_reg : '0;

endmodule

// File: rtl/zero_turn_sram.sv
module zero_turn_sram
  import zt_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DW = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clk_en,
  input  logic              sleep,
  input  logic              sel_n1,
  input  logic              sel_p2,
  input  logic              sel_n3,
  input  logic              adv,
  input  logic              wr_en,
  input  logic [LANES-1:0]  lane_we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  input  logic              burst_ilv,
  input  logic              out_en,
  output logic [DW-1:0]     rdata,
  output logic              rvalid
);

  op_e               cmd_op;
  logic [ADDR_W-1:0] cmd_addr;
  logic [LANES-1:0]  cmd_lanes;
  op_e               a_op;
  op_e               b_op;
  logic [ADDR_W-1:0] a_addr;
  logic [ADDR_W-1:0] b_addr;
  logic              wr_go;
  logic [LANES-1:0]  wr_lanes;
  logic [LANES-1:0]  fwd_lanes;
  logic [DW-1:0]     fwd_data;
  logic [DW-1:0]     ram_q;
  logic              drive_q;
  logic [DW-1:0]     q_reg;

  zt_cmd_decode #(.AW(ADDR_W), .LN(LANES)) i_dec (
    .clk(clk), .rst(rst), .clk_en(clk_en), .sleep(sleep),
    .sel_n1(sel_n1), .sel_p2(sel_p2), .sel_n3(sel_n3),
    .adv(adv), .wr_en(wr_en), .burst_ilv(burst_ilv),
    .lane_we(lane_we), .addr(addr),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_lanes(cmd_lanes)
  );

  zt_write_registry #(.AW(ADDR_W), .LN(LANES), .LW(LANE_W)) i_reg (
    .clk(clk), .rst(rst), .clk_en(clk_en),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_lanes(cmd_lanes), .wdata(wdata),
    .a_op(a_op), .b_op(b_op), .a_addr(a_addr), .b_addr(b_addr),
    .wr_go(wr_go), .wr_lanes(wr_lanes),
    .fwd_lanes(fwd_lanes), .fwd_data(fwd_data)
  );

  zt_array #(.AW(ADDR_W), .LN(LANES), .LW(LANE_W)) i_arr (
    .clk(clk), .clk_en(clk_en),
    .we(wr_go), .waddr(b_addr), .wlanes(wr_lanes), .wdata(wdata),
    .raddr(a_addr), .rq(ram_q)
  );

  zt_out_stage #(.LN(LANES), .LW(LANE_W)) i_out (
    .clk(clk), .rst(rst), .clk_en(clk_en), .sleep(sleep),
    .rd_done(b_op == OP_RD), .ram_q(ram_q),
    .fwd_lanes(fwd_lanes), .fwd_data(fwd_data), .out_en(out_en),
    .drive_q(drive_q), .q_reg(q_reg), .rdata(rdata), .rvalid(rvalid)
  );

endmodule

// File: rtl/zero_turn_sram_chk.sv
module zero_turn_sram_chk
  import zt_pkg::*;
#(
  parameter int DW = 36
) (
  input logic          clk,
  input logic          rst,
  input logic          clk_en,
  input logic          sleep,
  input logic          adv,
  input logic          sel_n1,
  input logic          sel_p2,
  input logic          sel_n3,
  input op_e           a_op,
  input op_e           b_op,
  input logic          drive_q,
  input logic [DW-1:0] q_reg
);

  // R1: a read leaving stage B turns the output drive on
  a_r1_read_drives: assert property (@(posedge clk) disable iff (rst)
    (clk_en && b_op == OP_RD && !sleep) |=> drive_q);

  // R4: a disabled edge freezes pipeline and output register
  a_r4_freeze: assert property (@(posedge clk) disable iff (rst)
    !clk_en |=> ($stable(drive_q) && $stable(q_reg) && $stable(a_op) && $stable(b_op)));

  // R5: a load cycle without all three selects active starts nothing
  a_r5_deselect: assert property (@(posedge clk) disable iff (rst)
    (clk_en && !sleep && !adv && !(!sel_n1 && sel_p2 && !sel_n3)) |=> a_op == OP_IDLE);

  // R7: the write data edge leaves the output undriven
  a_r7_write_quiet: assert property (@(posedge clk) disable iff (rst)
    (clk_en && b_op == OP_WR) |=> !drive_q);

  // R11: sleep blocks new commands and the output drive
  a_r11_sleep: assert property (@(posedge clk) disable iff (rst)
    (clk_en && sleep) |=> (a_op == OP_IDLE && !drive_q));

  // R12: reset empties the pipeline
  a_r12_reset: assert property (@(posedge clk)
    rst |=> (a_op == OP_IDLE && b_op == OP_IDLE && !drive_q));

endmodule

bind zero_turn_sram zero_turn_sram_chk #(.DW(DW)) i_chk (
  .clk(clk), .rst(rst), .clk_en(clk_en), .sleep(sleep), .adv(adv),
  .sel_n1(sel_n1), .sel_p2(sel_p2), .sel_n3(sel_n3),
  .a_op(a_op), .b_op(b_op), .drive_q(drive_q), .q_reg(q_reg)
);

// File: tb/test_zero_turn_sram.sv
`timescale 1ns/1ps
module test_zero_turn_sram;

  localparam int AW = 6;
  localparam int LN = 4;
  localparam int LW = 9;
  localparam int DW = LN * LW;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst, ce, sl, n1, p2, n3, adv, we, ilv, oe;
  logic [LN-1:0] lanes;
  logic [AW-1:0] ad;
  logic [DW-1:0] wd;
  logic [DW-1:0] rdata;
  logic rvalid;

  int total = 0;
  int bad = 0;
  string req = "R12";

  always #2.5 clk = ~clk;

  zero_turn_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) i_zero_turn_sram (
    .clk(clk), .rst(rst), .clk_en(ce), .sleep(sl),
    .sel_n1(n1), .sel_p2(p2), .sel_n3(n3), .adv(adv), .wr_en(we),
    .lane_we(lanes), .addr(ad), .wdata(wd), .burst_ilv(ilv), .out_en(oe),
    .rdata(rdata), .rvalid(rvalid)
  );

  // behavioural reference: memory, burst state, two queued commands
  logic [DW-1:0] mem_m [DEPTH];
  int            q_op [2];
  logic [AW-1:0] q_ad [2];
  logic [LN-1:0] q_ln [2];
  int            m_bact, m_bop, m_ilv, m_cnt;
  logic [AW-1:0] m_base;
  logic          exp_drive = 1'b0;
  logic [DW-1:0] exp_q = '0;

  task automatic model_edge();
    int op;
    logic [AW-1:0] na;
    logic [1:0] low;
    if (rst) begin
      q_op[0] = 0; q_op[1] = 0; m_bact = 0; exp_drive = 1'b0;
      return;
    end
    if (!ce) return;
    exp_drive = 1'b0;
    if (q_op[1] == 2) begin
      for (int i = 0; i < LN; i++)
        if (q_ln[1][i]) mem_m[q_ad[1]][i*LW +: LW] = wd[i*LW +: LW];
    end else if (q_op[1] == 1) begin
      exp_q = mem_m[q_ad[1]];
      exp_drive = !sl;
    end
    op = 0; na = ad;
    if (sl) begin
      m_bact = 0;
    end else if (!adv) begin
      if (!n1 && p2 && !n3) begin
        op = we ? 2 : 1;
        m_bact = 1; m_bop = op; m_base = ad; m_cnt = 0; m_ilv = ilv;
      end else m_bact = 0;
    end else if (m_bact != 0) begin
      m_cnt = (m_cnt + 1) % 4;
      low = (m_ilv != 0) ? (m_base[1:0] ^ 2'(m_cnt)) : 2'((m_base[1:0] + m_cnt) % 4);
      na = {m_base[AW-1:2], low};
      op = m_bop;
    end
    q_op[1] = q_op[0]; q_ad[1] = q_ad[0]; q_ln[1] = q_ln[0];
    q_op[0] = op; q_ad[0] = na; q_ln[0] = lanes;
  endtask

  task automatic compare();
    logic ev;
    logic [DW-1:0] ed;
    ev = exp_drive && oe;
    ed = ev ? exp_q : '0;
    total++;
    if (rvalid !== ev) begin
      bad++;
      $display("FAIL %s rvalid actual=%0b expected=%0b", req, rvalid, ev);
    end
    total++;
    if (rdata !== ed) begin
      bad++;
      $display("FAIL %s rdata actual=%h expected=%h", req, rdata, ed);
    end
  endtask

  task automatic tick();
    wd = {4'($urandom), 32'($urandom)};
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic load_rd(input logic [AW-1:0] a);
    n1 = 0; p2 = 1; n3 = 0; adv = 0; we = 0; ad = a; tick();
  endtask

  task automatic load_wr(input logic [AW-1:0] a, input logic [LN-1:0] ln);
    n1 = 0; p2 = 1; n3 = 0; adv = 0; we = 1; ad = a; lanes = ln; tick();
  endtask

  task automatic step_adv(input logic [LN-1:0] ln);
    adv = 1; lanes = ln; tick();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      n1 = 1; adv = 0; tick();
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #200000;
    bad++;
    $display("FAIL watchdog run did not complete");
    summary();
    $finish;
  end

  initial begin
    rst = 1; ce = 1; sl = 0; n1 = 1; p2 = 1; n3 = 0; adv = 0; we = 0;
    ilv = 0; oe = 1; lanes = '1; ad = '0; wd = '0;
    m_bact = 0; m_bop = 0; m_ilv = 0; m_cnt = 0; m_base = '0;
    for (int i = 0; i < 2; i++) begin q_op[i] = 0; q_ad[i] = '0; q_ln[i] = '0; end
    for (int i = 0; i < DEPTH; i++) mem_m[i] = '0;

    // R12: reset state
    req = "R12";
    for (int i = 0; i < 3; i++) tick();
    rst = 0;
    adv = 1; tick(); tick();   // R10 after reset: advance with no burst

    // R2: fill every word with full-lane writes (keeps reference defined)
    req = "R2";
    for (int i = 0; i < DEPTH; i++) load_wr(AW'(i), '1);
    idle(2);

    // R1: back-to-back reads
    req = "R1";
    for (int i = 0; i < 8; i++) load_rd(AW'(i * 7 + 3));
    idle(3);

    // R2 / R3: partial lanes, alternate write/read on one word
    req = "R3";
    for (int i = 0; i < 12; i++) begin
      load_wr(AW'(5), LN'(i + 1));
      load_rd(AW'(5));
    end
    load_wr(AW'(9), 4'b0101); load_wr(AW'(9), 4'b1010); load_rd(AW'(9)); load_rd(AW'(9));
    idle(3);

    // R7: read immediately after write of a different word
    req = "R7";
    for (int i = 0; i < 6; i++) begin
      load_rd(AW'(i)); load_wr(AW'(i + 20), '1);
    end
    idle(3);

    // R4: clock enable gaps inside mixed traffic
    req = "R4";
    for (int i = 0; i < 30; i++) begin
      ce = (i % 3) != 1;
      if (i % 2 == 0) load_wr(AW'(i % 8), 4'b0011); else load_rd(AW'((i - 1) % 8));
    end
    ce = 1; idle(3);

    // R5: every non-selecting combination of chip selects
    req = "R5";
    for (int c = 0; c < 8; c++) begin
      if (c != 3'b010) begin
        n1 = c[0]; p2 = c[1]; n3 = c[2]; adv = 0; we = c[0]; ad = AW'(c); lanes = '1; tick();
      end
    end
    load_rd(AW'(12)); n1 = 1; adv = 0; tick(); step_adv('1); step_adv('1);
    idle(3);

    // R6: output enable gating
    req = "R6";
    for (int i = 0; i < 10; i++) begin
      oe = i[0];
      load_rd(AW'(i + 30));
    end
    oe = 1; idle(3);

    // R8: linear bursts, read and write
    req = "R8";
    ilv = 0;
    load_rd(AW'(6)); for (int i = 0; i < 5; i++) step_adv('1);
    load_wr(AW'(13), 4'b1111); for (int i = 0; i < 5; i++) step_adv(LN'(i + 2));
    load_rd(AW'(13)); for (int i = 0; i < 4; i++) step_adv('1);
    idle(3);

    // R9: interleaved burst, mode pin changed mid-burst
    req = "R9";
    ilv = 1;
    load_rd(AW'(7)); ilv = 0; for (int i = 0; i < 5; i++) step_adv('1);
    ilv = 1;
    load_wr(AW'(42), '1); for (int i = 0; i < 3; i++) step_adv(LN'(i * 5 + 1));
    ilv = 0;
    load_rd(AW'(40)); for (int i = 0; i < 3; i++) step_adv('1);
    idle(3);

    // R10: advance after a deselect
    req = "R10";
    load_rd(AW'(2)); idle(1); step_adv('1); step_adv('1); step_adv('1);
    idle(2);

    // R11: sleep cuts an output, blocks a write, ends a burst
    req = "R11";
    load_rd(AW'(3)); load_rd(AW'(4));
    sl = 1; load_wr(AW'(3), '1); sl = 0;
    step_adv('1); load_rd(AW'(3));
    load_rd(AW'(8)); step_adv('1); sl = 1; step_adv('1); sl = 0; step_adv('1);
    idle(3);

    // R3: random traffic
    req = "R3";
    for (int i = 0; i < 600; i++) begin
      ce    = ($urandom % 8) != 0;
      sl    = ($urandom % 25) == 0;
      adv   = ($urandom % 5) < 2;
      n1    = ($urandom % 10) == 0;
      p2    = ($urandom % 10) != 0;
      n3    = ($urandom % 10) == 0;
      we    = $urandom % 2;
      ilv   = $urandom % 2;
      oe    = ($urandom % 10) != 0;
      lanes = LN'($urandom);
      ad    = AW'($urandom % 16);
      tick();
    end
    ce = 1; sl = 0; oe = 1; idle(3);

    summary();
    $finish;
  end

endmodule